// File: doc/BRIEF.md
# Ten-Bit Addressed I2C Write Receiver

This block is the receiving end of an I2C bus for a master that writes to it using ten-bit addressing. It watches the open-drain clock and data lines through a synchroniser running on the system clock, recognises START, repeated START and STOP conditions, and compares the two address bytes the master sends against a programmed ten-bit slave address. Once both address bytes match, every byte that follows is shifted in and either acknowledged or refused by pulling or releasing the data line during the acknowledge slot.

The host side is a small register-style interface. Configuration inputs supply the slave address, a global enable, a general-call enable and an interrupt enable. Single-cycle pulses let software request a NAK for the next byte, read the received byte, and read the status. The block presents the last received byte, a receive-full flag, a STOP flag, the pending NAK request and an interrupt line. The data line output is an active-high pull-down enable that the pad logic turns into an open-drain drive.

The system clock must run at least eight times faster than the bus clock. The block never stretches the bus clock.

Top module: `i2c10_slave_rx`

## Requirements
- R1: After reset, sda_oe, rx_full, stop_flag, nak_bit, selected, gcall_hit and irq are all 0, and rx_data is 8'h00.
- R2: When cfg_enable is 1, a first byte after START (or repeated START) equal to {5'b11110, cfg_addr[9:8], 1'b0}, sent MSB first, is acknowledged. Any other first byte, or any first byte while cfg_enable is 0, gets no acknowledge. The block then ignores the bus until the next START or STOP.
- R3: After an acknowledged first byte, a second byte equal to cfg_addr[7:0] is acknowledged and sets selected. A different second byte gets no acknowledge, and selected stays 0.
- R4: While selected, each data byte is shifted in MSB first. It is acknowledged when nak_bit is 0 and rx_full is 0, and it is then stored in rx_data with rx_full set to 1.
- R5: A pulse on nak_set sets nak_bit. The next data byte is refused but still stored in rx_data, with rx_full set. Later bytes up to the next START or STOP are ignored.
- R6: A data byte that arrives while rx_full is 1 is refused, and rx_data keeps its earlier value.
- R7: A pulse on data_rd clears rx_full.
- R8: A STOP after the block was selected (by address or by general call) sets stop_flag, and a pulse on stat_rd clears it. A STOP while not selected leaves stop_flag at 0.
- R9: Any START, repeated START or STOP clears nak_bit.
- R10: With cfg_gce at 1 and cfg_enable at 1, a first byte of 8'h00 is acknowledged and sets gcall_hit and selected, and the bytes after it are data. With cfg_gce at 0, that byte gets no acknowledge.
- R11: irq equals cfg_ien AND (rx_full OR stop_flag).
- R12: A repeated START in the middle of a transfer clears selected and restarts the two-byte address phase.
- R13: sda_oe changes only while the synchronised bus clock is low. It is asserted from the clock fall after the eighth bit of an acknowledged byte until the next clock fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low |
| cfg_enable | input | 1 | Slave enable |
| cfg_gce | input | 1 | Answer the general-call address |
| cfg_ien | input | 1 | Interrupt enable |
| cfg_addr | input | 10 | Programmed ten-bit slave address |
| nak_set | input | 1 | Pulse: refuse the next data byte |
| data_rd | input | 1 | Pulse: software read of rx_data |
| stat_rd | input | 1 | Pulse: software read of the status |
| rx_data | output | 8 | Last stored data byte |
| rx_full | output | 1 | Unread byte in rx_data |
| stop_flag | output | 1 | STOP seen after being selected |
| nak_bit | output | 1 | NAK request pending |
| selected | output | 1 | Addressed since the last START |
| gcall_hit | output | 1 | Selected by general call |
| irq | output | 1 | Interrupt request |

## Verification
The bench sends headers with a wrong upper address pair, with the direction bit set, and with the enable off. A design that matched only part of the header, or that skipped the direction bit, would acknowledge these. A wrong low address byte must leave the block silent for the rest of the transfer, so a slave that returned to the header phase would acknowledge the later bytes. A requested NAK must refuse the byte but still store it. A byte that arrives while the previous one is unread must leave rx_data unchanged; a design that overwrote it would lose data that was already acknowledged. Repeated START and STOP must clear the NAK request, or the next transfer would be refused. Random transfers mix correct and wrong addresses, byte counts, and a NAK on the last byte.

// File: rtl/i2c10_pkg.sv
package i2c10_pkg;

  localparam int BYTE_W = 8;
  localparam int SLA_W  = 10;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  localparam logic [4:0]        TEN_BIT_TAG = 5'b11110;
  localparam logic [BYTE_W-1:0] GCALL_BYTE  = '0;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_HDR,
    PH_LOW,
    PH_DATA,
    PH_ACK,
    PH_SKIP
  } phase_t;

  // Header byte a master sends to write to a ten-bit address
  function automatic logic [BYTE_W-1:0] hdr_byte(input logic [SLA_W-1:0] a);
    return {TEN_BIT_TAG, a[SLA_W-1 -: 2], 1'b0};
  endfunction

  // A data byte is accepted only with no NAK request and an empty holding register
  function automatic logic rx_accept(input logic nak_req, input logic full);
    return !nak_req && !full;
  endfunction

  function automatic logic irq_level(input logic ien, input logic full, input logic stp);
    return ien && (full || stp);
  endfunction

endpackage

// File: rtl/i2c10_line_sync.sv
module i2c10_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  localparam int NLINES = 2;   // index 1 = clock line, 0 = data line

  logic [NLINES-1:0] pins;
  logic [NLINES-1:0] lvl;
  logic [NLINES-1:0] lvl_q;

  assign pins = {scl_i, sda_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], pins[g]};
    end
    assign lvl[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '1;
    else        lvl_q <= lvl;
  end

  assign scl_lvl  = lvl[1];
  assign sda_lvl  = lvl[0];
  assign scl_rise = lvl[1] && !lvl_q[1];
  assign scl_fall = !lvl[1] && lvl_q[1];
  // conditions are only valid while the clock has been high for two samples
  assign start_ev = lvl[1] && lvl_q[1] && lvl_q[0] && !lvl[0];
  assign stop_ev  = lvl[1] && lvl_q[1] && !lvl_q[0] && lvl[0];

endmodule

// File: rtl/i2c10_rx_fsm.sv
module i2c10_rx_fsm
  import i2c10_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_lvl,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              cfg_enable,
  input  logic              cfg_gce,
  input  logic [SLA_W-1:0]  cfg_addr,
  input  logic              nak_bit,
  input  logic              rx_full,
  output logic              sda_oe,
  output logic              selected,
  output logic              gcall_hit,
  output logic              byte_ev,
  output logic [BYTE_W-1:0] byte_val,
  output logic              stop_sel_ev
);

  phase_t             phase_q;
  phase_t             after_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [BYTE_W-1:0]  sh_q;
  logic               oe_q;
  logic               sel_q;
  logic               gc_q;

  logic in_byte, shift_en, byte_end, hdr_hit, gc_hit, low_hit, data_ok;

  assign in_byte  = (phase_q == PH_HDR) || (phase_q == PH_LOW) || (phase_q == PH_DATA);
  assign shift_en = in_byte && scl_rise && (cnt_q < CNT_W'(BYTE_W));
  assign byte_end = scl_fall && (cnt_q == CNT_W'(BYTE_W));
  assign hdr_hit  = cfg_enable && (sh_q == hdr_byte(cfg_addr));
  assign gc_hit   = cfg_enable && cfg_gce && (sh_q == GCALL_BYTE);
  assign low_hit  = (sh_q == cfg_addr[BYTE_W-1:0]);
  assign data_ok  = rx_accept(nak_bit, rx_full);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      after_q <= PH_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      oe_q    <= 1'b0;
      sel_q   <= 1'b0;
      gc_q    <= 1'b0;
    end else if (start_ev) begin
      phase_q <= PH_HDR;
      cnt_q   <= '0;
      oe_q    <= 1'b0;
      sel_q   <= 1'b0;
      gc_q    <= 1'b0;
    end else if (stop_ev) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      oe_q    <= 1'b0;
      sel_q   <= 1'b0;
      gc_q    <= 1'b0;
    end else if (shift_en) begin
      sh_q  <= {sh_q[BYTE_W-2:0], sda_lvl};
      cnt_q <= cnt_q + 1'b1;
    end else if (phase_q == PH_ACK) begin
      if (scl_fall) begin
        oe_q    <= 1'b0;
        cnt_q   <= '0;
        phase_q <= after_q;
      end
    end else if (in_byte && byte_end) begin
      case (phase_q)
        PH_HDR: begin
          if (hdr_hit) begin
            oe_q    <= 1'b1;
            phase_q <= PH_ACK;
            after_q <= PH_LOW;
          end else if (gc_hit) begin
            oe_q    <= 1'b1;
            phase_q <= PH_ACK;
            after_q <= PH_DATA;
            sel_q   <= 1'b1;
            gc_q    <= 1'b1;
          end else begin
            phase_q <= PH_SKIP;
          end
        end
        PH_LOW: begin
          if (low_hit) begin
            oe_q    <= 1'b1;
            phase_q <= PH_ACK;
            after_q <= PH_DATA;
            sel_q   <= 1'b1;
          end else begin
            phase_q <= PH_SKIP;
          end
        end
        default: begin
          if (data_ok) begin
            oe_q    <= 1'b1;
            phase_q <= PH_ACK;
            after_q <= PH_DATA;
          end else begin
            phase_q <= PH_SKIP;
          end
        end
      endcase
    end
  end

  assign sda_oe      = oe_q;
  assign selected    = sel_q;
  assign gcall_hit   = gc_q;
  assign byte_ev     = byte_end && (phase_q == PH_DATA);
  assign byte_val    = sh_q;
  assign stop_sel_ev = stop_ev && sel_q;

  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe_q) |-> !scl_lvl);                          // R13
  AST_DATA_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ev |-> sel_q);                                    // R3
  AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SKIP) |-> !oe_q);                       // R5

endmodule

// File: rtl/i2c10_rx_regs.sv
module i2c10_rx_regs
  import i2c10_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_ev,
  input  logic [BYTE_W-1:0] byte_val,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              stop_sel_ev,
  input  logic              data_rd,
  input  logic              stat_rd,
  input  logic              nak_set,
  input  logic              cfg_ien,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_full,
  output logic              stop_flag,
  output logic              nak_bit,
  output logic              irq
);

  logic [BYTE_W-1:0] data_q;
  logic              full_q, stop_q, nak_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      full_q <= 1'b0;
    end else if (byte_ev && !full_q) begin
      data_q <= byte_val;
      full_q <= 1'b1;
    end else if (data_rd) begin
      full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           stop_q <= 1'b0;
    else if (stop_sel_ev) stop_q <= 1'b1;
    else if (stat_rd)     stop_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  nak_q <= 1'b0;
    else if (start_ev || stop_ev) nak_q <= 1'b0;
    else if (nak_set)            nak_q <= 1'b1;
  end

  assign rx_data   = data_q;
  assign rx_full   = full_q;
  assign stop_flag = stop_q;
  assign nak_bit   = nak_q;
  assign irq       = irq_level(cfg_ien, full_q, stop_q);

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    full_q && !data_rd |=> $stable(data_q));               // R6
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd && !byte_ev |=> !full_q);                      // R7
  AST_STOP_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_q) |-> $past(stop_sel_ev));                 // R8
  AST_NAK_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ev || stop_ev) |=> !nak_q);                     // R9

endmodule

// File: rtl/i2c10_slave_rx.sv
module i2c10_slave_rx
  import i2c10_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              cfg_enable,
  input  logic              cfg_gce,
  input  logic              cfg_ien,
  input  logic [SLA_W-1:0]  cfg_addr,
  input  logic              nak_set,
  input  logic              data_rd,
  input  logic              stat_rd,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_full,
  output logic              stop_flag,
  output logic              nak_bit,
  output logic              selected,
  output logic              gcall_hit,
  output logic              irq
);

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
  logic byte_ev, stop_sel_ev;
  logic [BYTE_W-1:0] byte_val;

  i2c10_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_lvl  (scl_lvl),
    .sda_lvl  (sda_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  i2c10_rx_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_lvl     (scl_lvl),
    .sda_lvl     (sda_lvl),
    .scl_rise    (scl_rise),
    .scl_fall    (scl_fall),
    .start_ev    (start_ev),
    .stop_ev     (stop_ev),
    .cfg_enable  (cfg_enable),
    .cfg_gce     (cfg_gce),
    .cfg_addr    (cfg_addr),
    .nak_bit     (nak_bit),
    .rx_full     (rx_full),
    .sda_oe      (sda_oe),
    .selected    (selected),
    .gcall_hit   (gcall_hit),
    .byte_ev     (byte_ev),
    .byte_val    (byte_val),
    .stop_sel_ev (stop_sel_ev)
  );

  i2c10_rx_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .byte_ev     (byte_ev),
    .byte_val    (byte_val),
    .start_ev    (start_ev),
    .stop_ev     (stop_ev),
    .stop_sel_ev (stop_sel_ev),
    .data_rd     (data_rd),
    .stat_rd     (stat_rd),
    .nak_set     (nak_set),
    .cfg_ien     (cfg_ien),
    .rx_data     (rx_data),
    .rx_full     (rx_full),
    .stop_flag   (stop_flag),
    .nak_bit     (nak_bit),
    .irq         (irq)
  );

endmodule

// File: tb/i2c10_slave_rx_tb_top.sv
module i2c10_slave_rx_tb_top;

  localparam int Q = 10;  // quarter of a bus clock period, in system clocks

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic cfg_enable = 1'b1, cfg_gce = 1'b0, cfg_ien = 1'b1;
  logic [9:0] cfg_addr = 10'h2A5;
  logic nak_set = 1'b0, data_rd = 1'b0, stat_rd = 1'b0;
  logic sda_oe, rx_full, stop_flag, nak_bit, selected, gcall_hit, irq;
  logic [7:0] rx_data;
  logic sda_bus;

  assign sda_bus = sda_m & ~sda_oe;

  i2c10_slave_rx dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .cfg_enable(cfg_enable), .cfg_gce(cfg_gce), .cfg_ien(cfg_ien), .cfg_addr(cfg_addr),
    .nak_set(nak_set), .data_rd(data_rd), .stat_rd(stat_rd),
    .rx_data(rx_data), .rx_full(rx_full), .stop_flag(stop_flag), .nak_bit(nak_bit),
    .selected(selected), .gcall_hit(gcall_hit), .irq(irq)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_data_rd; data_rd = 1'b1; wq(1); data_rd = 1'b0; wq(1); endtask
  task automatic pulse_stat_rd; stat_rd = 1'b1; wq(1); stat_rd = 1'b0; wq(1); endtask
  task automatic pulse_nak;     nak_set = 1'b1; wq(1); nak_set = 1'b0; wq(1); endtask

  task automatic m_start;
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic m_stop;
    sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
  endtask

  task automatic m_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(Q); scl_m = 1'b1; wq(2 * Q); scl_m = 1'b0; wq(Q);
    end
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
    acked = !sda_bus;
    wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  // expected answers, written from the requirements
  function automatic logic [7:0] exp_hdr(input logic [9:0] a);
    return {2'b11, 3'b110, a[9], a[8], 1'b0};
  endfunction

  function automatic bit exp_first_ack(input logic [7:0] b, input logic [9:0] a,
                                       input bit en, input bit gce);
    return en && ((b == exp_hdr(a)) || (gce && b == 8'h00));
  endfunction

  function automatic bit exp_irq(input bit ien, input bit full, input bit stp);
    return ien & (full | stp);
  endfunction

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    finish_run();
  end

  initial begin
    bit ack;
    logic [7:0] d;
    void'($urandom(32'h5EED_0A11));
    wq(5);
    rst_n = 1'b1;
    wq(5);

    // R1 reset state
    eq("R1 sda_oe", sda_oe, 0);
    eq("R1 rx_full", rx_full, 0);
    eq("R1 stop_flag", stop_flag, 0);
    eq("R1 nak_bit", nak_bit, 0);
    eq("R1 selected", selected, 0);
    eq("R1 gcall_hit", gcall_hit, 0);
    eq("R1 irq", irq, 0);
    eq("R1 rx_data", rx_data, 0);

    // normal three-byte write
    m_start();
    m_byte(exp_hdr(cfg_addr), ack); eq("R2 header ack", ack, 1);
    m_byte(cfg_addr[7:0], ack);     eq("R3 low byte ack", ack, 1);
    eq("R3 selected", selected, 1);
    for (int k = 0; k < 3; k++) begin
      d = 8'h3C + 8'(k * 8'h41);
      m_byte(d, ack);
      eq("R4 data ack", ack, 1);
      eq("R4 rx_data", rx_data, d);
      eq("R4 rx_full", rx_full, 1);
      eq("R11 irq on full", irq, exp_irq(cfg_ien, 1, 0));
      pulse_data_rd();
      eq("R7 rx_full cleared", rx_full, 0);
    end
    m_stop();
    eq("R8 stop flag", stop_flag, 1);
    eq("R11 irq on stop", irq, 1);
    pulse_stat_rd();
    eq("R8 stop cleared", stop_flag, 0);
    eq("R11 irq idle", irq, 0);

    // wrong upper address bits
    m_start();
    m_byte(exp_hdr(cfg_addr) ^ 8'h02, ack); eq("R2 wrong header nak", ack, 0);
    m_byte(cfg_addr[7:0], ack);             eq("R2 ignored until start", ack, 0);
    m_stop();
    eq("R8 no flag unselected", stop_flag, 0);

    // direction bit set
    m_start();
    m_byte(exp_hdr(cfg_addr) | 8'h01, ack); eq("R2 read bit nak", ack, 0);
    m_stop();

    // wrong low address byte
    m_start();
    m_byte(exp_hdr(cfg_addr), ack);        eq("R2 header ack", ack, 1);
    m_byte(cfg_addr[7:0] ^ 8'h10, ack);    eq("R3 wrong low nak", ack, 0);
    eq("R3 not selected", selected, 0);
    m_byte(8'h77, ack);                    eq("R3 later byte nak", ack, 0);
    eq("R3 nothing stored", rx_full, 0);
    m_stop();
    eq("R8 no flag after low miss", stop_flag, 0);

    // software NAK request
    m_start();
    m_byte(exp_hdr(cfg_addr), ack);
    m_byte(cfg_addr[7:0], ack);
    pulse_nak();
    eq("R5 nak_bit set", nak_bit, 1);
    m_byte(8'hA7, ack);                    eq("R5 refused", ack, 0);
    eq("R5 stored", rx_data, 8'hA7);
    eq("R5 rx_full", rx_full, 1);
    pulse_data_rd();
    m_byte(8'h19, ack);                    eq("R5 later ignored", ack, 0);
    eq("R5 later not stored", rx_full, 0);
    m_stop();
    eq("R9 nak cleared by stop", nak_bit, 0);
    pulse_stat_rd();

    // overrun
    m_start();
    m_byte(exp_hdr(cfg_addr), ack);
    m_byte(cfg_addr[7:0], ack);
    m_byte(8'h5A, ack);                    eq("R4 first ack", ack, 1);
    m_byte(8'hC3, ack);                    eq("R6 overrun nak", ack, 0);
    eq("R6 data kept", rx_data, 8'h5A);
    m_stop();
    pulse_data_rd();
    pulse_stat_rd();

    // repeated start
    m_start();
    m_byte(exp_hdr(cfg_addr), ack);
    m_byte(cfg_addr[7:0], ack);
    m_byte(8'h11, ack);
    pulse_data_rd();
    pulse_nak();
    m_start();
    eq("R9 nak cleared by restart", nak_bit, 0);
    eq("R12 selected cleared", selected, 0);
    m_byte(exp_hdr(cfg_addr), ack);        eq("R12 header after restart", ack, 1);
    m_byte(cfg_addr[7:0], ack);            eq("R12 low after restart", ack, 1);
    m_byte(8'hE4, ack);                    eq("R12 data after restart", ack, 1);
    eq("R12 rx_data", rx_data, 8'hE4);
    pulse_data_rd();
    m_stop();
    pulse_stat_rd();

    // general call
    cfg_gce = 1'b1;
    m_start();
    m_byte(8'h00, ack);                    eq("R10 gc ack", ack, 1);
    eq("R10 gcall_hit", gcall_hit, 1);
    m_byte(8'h6D, ack);                    eq("R10 gc data ack", ack, 1);
    eq("R10 gc data", rx_data, 8'h6D);
    pulse_data_rd();
    m_stop();
    eq("R8 flag after gc", stop_flag, 1);
    pulse_stat_rd();
    cfg_gce = 1'b0;
    m_start();
    m_byte(8'h00, ack);                    eq("R10 gc disabled nak", ack, 0);
    m_stop();

    // disabled
    cfg_enable = 1'b0;
    m_start();
    m_byte(exp_hdr(cfg_addr), ack);        eq("R2 disabled nak", ack, 0);
    m_stop();
    cfg_enable = 1'b1;

    // interrupt enable off
    cfg_ien = 1'b0;
    m_start();
    m_byte(exp_hdr(cfg_addr), ack);
    m_byte(cfg_addr[7:0], ack);
    m_byte(8'h2B, ack);
    eq("R11 irq masked", irq, 0);
    pulse_data_rd();
    m_stop();
    eq("R11 irq masked stop", irq, 0);
    pulse_stat_rd();
    cfg_ien = 1'b1;

    // random transfers
    for (int t = 0; t < 24; t++) begin
      logic [7:0] hdr, lo;
      bit e1, e2, sel, use_nak;
      int nb;
      cfg_addr = 10'($urandom);
      hdr = ($urandom % 3 != 0) ? exp_hdr(cfg_addr) : 8'($urandom);
      lo  = ($urandom % 3 != 0) ? cfg_addr[7:0] : 8'($urandom);
      e1  = exp_first_ack(hdr, cfg_addr, 1'b1, 1'b0);
      e2  = e1 && (lo == cfg_addr[7:0]);
      sel = e2;
      nb  = 1 + int'($urandom % 3);
      use_nak = ($urandom % 2) == 1;
      m_start();
      m_byte(hdr, ack); eq("R2 random header", ack, e1);
      if (e1) begin
        m_byte(lo, ack); eq("R3 random low", ack, e2);
        for (int k = 0; k < nb; k++) begin
          bit last_nak;
          last_nak = use_nak && (k == nb - 1);
          d = 8'($urandom);
          if (last_nak) pulse_nak();
          m_byte(d, ack);
          eq("R4 random data ack", ack, sel && !last_nak);
          eq("R4 random rx_full", rx_full, sel);
          if (sel) begin
            eq("R5 random rx_data", rx_data, d);
            pulse_data_rd();
          end
        end
      end
      m_stop();
      eq("R8 random stop flag", stop_flag, sel);
      eq("R9 random nak clear", nak_bit, 0);
      pulse_stat_rd();
    end

    finish_run();
  end

endmodule